// File: doc/BRIEF.md
# Two-Channel DMA Address and Count Register File

This block holds the programmable addresses and transfer counts of a two-channel DMA controller. Each channel keeps a 32-bit requester address, a 32-bit target address and a 24-bit byte count. Software reaches them over an 8-bit data bus with a 16-bit I/O port address. All current register values are presented in parallel to the transfer engine.

Many port addresses are shared by two bytes. A single pointer flip-flop, common to both channels and to every shared port, decides which byte of the pair an access reaches. The pointer flips after each access to a shared port. A dedicated write-only command address forces it back to zero, so software can start a sequence from a known state. Some upper address and count bytes sit at their own direct port addresses and never involve the pointer.

Top module: `dmarf_top`

## Requirements
- R1: After reset every register byte is 0x00, the pointer is 0, and `rd_data` is 0x00.
- R2: On a shared port, pointer 0 reaches the lower byte of the pair and pointer 1 the upper byte. The shared ports are: 0xF010 for requester bytes 0/1 and 0xF011 for requester bytes 2/3 of channel 0; 0xF012 and 0xF013 for the same bytes of channel 1; 0xF000 for target bytes 0/1 of channel 0 and 0xF002 for those of channel 1; 0xF001 for count bytes 0/1 of channel 0 and 0xF003 for those of channel 1.
- R3: Every read or write to a shared port flips the single pointer, which is shared by all shared ports of both channels. An access with both strobes high flips it only once.
- R4: A write to 0xF00C or 0x000C clears the pointer to 0 whatever the data, and it changes no register byte.
- R5: The direct ports never use or change the pointer. For channel 0, target byte 2 is at 0xF087, target byte 3 at 0xF086 and count byte 2 at 0xF098. For channel 1, target byte 2 is at 0xF083, target byte 3 at 0xF085 and count byte 2 at 0xF099.
- R6: While `rd_en` is high, `rd_data` shows the addressed byte in the same cycle. If `wr_en` is also high, it shows the value held before the write. While `rd_en` is low, `rd_data` is 0x00.
- R7: A read of any address outside the map returns 0x00. An access outside the map, the clear addresses included, changes no register byte and leaves the pointer unchanged (apart from the clear of R4).
- R8: A write stores `wr_data` in the addressed byte, and the parallel outputs show it from the next clock edge onward. Channel 1 sits in the upper half of each parallel output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | I/O port address |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data byte, combinational |
| req_addr | output | 64 | Requester addresses, channel 1 in bits 63:32 |
| tgt_addr | output | 64 | Target addresses, channel 1 in bits 63:32 |
| byte_cnt | output | 48 | Byte counts, channel 1 in bits 47:24 |

## Verification
Directed sequences come first:
- Byte pairs written through one shared port show that the pointer alternates.
- A clear issued between the two halves of a pair tells a correct clear from a missing one.
- Direct-port accesses placed between the halves of a pair expose any pointer disturbance.
- Unmapped and dual-strobe accesses separate the no-effect and single-toggle rules.

A long random mix of reads, writes and clears over the mapped, clear and random addresses then exercises the pointer across channels and register kinds. It is compared byte by byte against an address-bit model of the map kept in the bench.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int NUM_CH    = 2;
  localparam int REQ_BYTES = 4;
  localparam int TGT_BYTES = 4;
  localparam int CNT_BYTES = 3;
  localparam int IDX_W     = 2;
  localparam int CH_W      = 1;

  typedef enum logic [1:0] {RK_REQ = 2'd0, RK_TGT = 2'd1, RK_CNT = 2'd2} reg_kind_t;

  typedef struct packed {
    logic             hit;      // a register byte is addressed
    logic             ptr;      // the byte is selected through the pointer
    logic             clr;      // pointer clear command
    logic [CH_W-1:0]  ch;
    reg_kind_t        kind;
    logic [IDX_W-1:0] idx;
  } dec_t;

  function automatic dec_t mk(input logic p, input logic [CH_W-1:0] c,
                              input reg_kind_t k, input logic [IDX_W-1:0] i);
    dec_t d;
    d.hit = 1'b1; d.ptr = p; d.clr = 1'b0; d.ch = c; d.kind = k; d.idx = i;
    return d;
  endfunction

  // Address map decode; the pointer picks the low/high byte on shared ports.
  function automatic dec_t decode_access(input logic [ADDR_W-1:0] a, input logic bp);
    dec_t d;
    d = '0;
    d.kind = RK_REQ;
    case (a)
      16'hF010: d = mk(1'b1, 1'b0, RK_REQ, {1'b0, bp});
      16'hF011: d = mk(1'b1, 1'b0, RK_REQ, {1'b1, bp});
      16'hF000: d = mk(1'b1, 1'b0, RK_TGT, {1'b0, bp});
      16'hF087: d = mk(1'b0, 1'b0, RK_TGT, 2'd2);
      16'hF086: d = mk(1'b0, 1'b0, RK_TGT, 2'd3);
      16'hF001: d = mk(1'b1, 1'b0, RK_CNT, {1'b0, bp});
      16'hF098: d = mk(1'b0, 1'b0, RK_CNT, 2'd2);
      16'hF012: d = mk(1'b1, 1'b1, RK_REQ, {1'b0, bp});
      16'hF013: d = mk(1'b1, 1'b1, RK_REQ, {1'b1, bp});
      16'hF002: d = mk(1'b1, 1'b1, RK_TGT, {1'b0, bp});
      16'hF083: d = mk(1'b0, 1'b1, RK_TGT, 2'd2);
      16'hF085: d = mk(1'b0, 1'b1, RK_TGT, 2'd3);
      16'hF003: d = mk(1'b1, 1'b1, RK_CNT, {1'b0, bp});
      16'hF099: d = mk(1'b0, 1'b1, RK_CNT, 2'd2);
      16'hF00C, 16'h000C: d.clr = 1'b1;
      default: d = d;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/dmarf_byteptr.sv
module dmarf_byteptr (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clear,
  output logic bp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bp <= 1'b0;
    else if (clear) bp <= 1'b0;
    else if (step)  bp <= ~bp;
  end

  // R4: a clear always leaves the pointer at zero
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !bp);
  // R3: exactly one flip per stepping access
  a_r3_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |=> (bp != $past(bp)));
endmodule

// File: rtl/dmarf_decode.sv
module dmarf_decode
  import dmarf_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              bp,
  output dec_t              dec
);
  always_comb dec = decode_access(addr, bp);
endmodule

// File: rtl/dmarf_chan_regs.sv
module dmarf_chan_regs
  import dmarf_pkg::*;
#(
  parameter int RB = REQ_BYTES,
  parameter int TB = TGT_BYTES,
  parameter int CB = CNT_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  reg_kind_t          kind,
  input  logic [IDX_W-1:0]   idx,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rbyte,
  output logic [RB*DATA_W-1:0] req,
  output logic [TB*DATA_W-1:0] tgt,
  output logic [CB*DATA_W-1:0] cnt
);
  logic [DATA_W-1:0] req_q [RB];
  logic [DATA_W-1:0] tgt_q [TB];
  logic [DATA_W-1:0] cnt_q [CB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RB; i++) req_q[i] <= '0;
      for (int i = 0; i < TB; i++) tgt_q[i] <= '0;
      for (int i = 0; i < CB; i++) cnt_q[i] <= '0;
    end else if (we) begin
      case (kind)
        RK_REQ: if (int'(idx) < RB) req_q[idx] <= wdata;
        RK_TGT: if (int'(idx) < TB) tgt_q[idx] <= wdata;
        RK_CNT: if (int'(idx) < CB) cnt_q[idx] <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rbyte = '0;
    case (kind)
      RK_REQ: if (int'(idx) < RB) rbyte = req_q[idx];
      RK_TGT: if (int'(idx) < TB) rbyte = tgt_q[idx];
      RK_CNT: if (int'(idx) < CB) rbyte = cnt_q[idx];
      default: rbyte = '0;
    endcase
  end

  for (genvar g = 0; g < RB; g++) begin : g_req
    assign req[g*DATA_W +: DATA_W] = req_q[g];
  end
  for (genvar g = 0; g < TB; g++) begin : g_tgt
    assign tgt[g*DATA_W +: DATA_W] = tgt_q[g];
  end
  for (genvar g = 0; g < CB; g++) begin : g_cnt
    assign cnt[g*DATA_W +: DATA_W] = cnt_q[g];
  end

  // R8: registers hold when this channel is not written
  a_r8_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(req) && $stable(tgt) && $stable(cnt)));
  // R8: the written requester byte appears on the parallel output
  a_r8_req_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && kind == RK_REQ) |=> (req[$past(idx)*DATA_W +: DATA_W] == $past(wdata)));
endmodule

// File: rtl/dmarf_top.sv
module dmarf_top
  import dmarf_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             wr_en,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             rd_en,
  output logic [DATA_W-1:0]                rd_data,
  output logic [NUM_CH*REQ_BYTES*DATA_W-1:0] req_addr,
  output logic [NUM_CH*TGT_BYTES*DATA_W-1:0] tgt_addr,
  output logic [NUM_CH*CNT_BYTES*DATA_W-1:0] byte_cnt
);
  localparam int RW = REQ_BYTES * DATA_W;
  localparam int TW = TGT_BYTES * DATA_W;
  localparam int CW = CNT_BYTES * DATA_W;

  logic              bp;
  dec_t              dec;
  logic              access;
  logic              ptr_step;
  logic              clr_cmd;
  logic [DATA_W-1:0] ch_rbyte [NUM_CH];

  assign access   = wr_en | rd_en;
  assign ptr_step = access & dec.hit & dec.ptr;
  assign clr_cmd  = wr_en & dec.clr;

  dmarf_decode u_dec (.addr(addr), .bp(bp), .dec(dec));

  dmarf_byteptr u_bp (.clk(clk), .rst_n(rst_n), .step(ptr_step), .clear(clr_cmd), .bp(bp));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ch_we;
    assign ch_we = wr_en & dec.hit & (dec.ch == CH_W'(c));
    dmarf_chan_regs u_regs (
      .clk(clk), .rst_n(rst_n), .we(ch_we), .kind(dec.kind), .idx(dec.idx),
      .wdata(wr_data), .rbyte(ch_rbyte[c]),
      .req(req_addr[c*RW +: RW]), .tgt(tgt_addr[c*TW +: TW]), .cnt(byte_cnt[c*CW +: CW]));
  end

  assign rd_data = (rd_en && dec.hit) ? ch_rbyte[dec.ch] : '0;

  // R7: unmapped reads return zero
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !dec.hit) |-> (rd_data == '0));
  // R6: no read strobe, no read data
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));
  // R5: direct-port and unmapped accesses leave the pointer alone
  a_r5_direct_keeps_bp: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !(dec.hit && dec.ptr) && !clr_cmd) |=> $stable(bp));
  // R7: clear and unmapped writes leave all registers alone
  a_r7_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !dec.hit) |=> ($stable(req_addr) && $stable(tgt_addr) && $stable(byte_cnt)));
  // R4: clear command from the ports yields pointer zero
  a_r4_port_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 16'hF00C || addr == 16'h000C)) |=> !bp);
endmodule

// File: tb/tb_dmarf_top.sv
module tb_dmarf_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [63:0] req_addr;
  logic [63:0] tgt_addr;
  logic [47:0] byte_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] mreq [2];
  logic [31:0] mtgt [2];
  logic [23:0] mcnt [2];
  bit          mbp;

  always #4 clk = ~clk;

  dmarf_top dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
                 .rd_en(rd_en), .rd_data(rd_data), .req_addr(req_addr), .tgt_addr(tgt_addr),
                 .byte_cnt(byte_cnt));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Locate a byte by address bits: rk 0=req 1=tgt 2=cnt, sh = bit offset
  task automatic locate(input logic [15:0] a, output int ch, output int rk,
                        output int sh, output bit ptr);
    ch = -1; rk = 0; sh = 0; ptr = 0;
    if (a >= 16'hF010 && a <= 16'hF013) begin
      ch = a[1]; rk = 0; ptr = 1; sh = a[0] * 16 + mbp * 8;
    end else if (a <= 16'hF003 && a >= 16'hF000) begin
      ch = a[1]; rk = a[0] ? 2 : 1; ptr = 1; sh = mbp * 8;
    end else begin
      case (a)
        16'hF087: begin ch = 0; rk = 1; sh = 16; end
        16'hF086: begin ch = 0; rk = 1; sh = 24; end
        16'hF098: begin ch = 0; rk = 2; sh = 16; end
        16'hF083: begin ch = 1; rk = 1; sh = 16; end
        16'hF085: begin ch = 1; rk = 1; sh = 24; end
        16'hF099: begin ch = 1; rk = 2; sh = 16; end
        default: ch = -1;
      endcase
    end
  endtask

  function automatic logic [7:0] model_byte(input int ch, input int rk, input int sh);
    if (ch < 0) return 8'h00;
    case (rk)
      0: return mreq[ch][sh +: 8];
      1: return mtgt[ch][sh +: 8];
      default: return mcnt[ch][sh +: 8];
    endcase
  endfunction

  task automatic compare_outputs(input string tag);
    check({tag, " R8 req"}, {32'h0, req_addr}, {32'h0, mreq[1], mreq[0]});
    check({tag, " R8 tgt"}, {32'h0, tgt_addr}, {32'h0, mtgt[1], mtgt[0]});
    check({tag, " R8 cnt"}, {16'h0, byte_cnt}, {16'h0, mcnt[1], mcnt[0]});
  endtask

  // One access: inputs driven at negedge, read sampled before the edge.
  task automatic access(input logic [15:0] a, input bit wr, input bit rd,
                        input logic [7:0] d, input string tag);
    int ch, rk, sh; bit ptr;
    logic [7:0] exp_rd;
    @(negedge clk);
    locate(a, ch, rk, sh, ptr);
    exp_rd = rd ? model_byte(ch, rk, sh) : 8'h00;
    addr = a; wr_en = wr; rd_en = rd; wr_data = d;
    #1;
    check({tag, " R6 rd_data"}, {56'h0, rd_data}, {56'h0, exp_rd});
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    if (wr && ch >= 0) begin
      case (rk)
        0: mreq[ch][sh +: 8] = d;
        1: mtgt[ch][sh +: 8] = d;
        default: mcnt[ch][sh +: 8] = d;
      endcase
    end
    if (ptr && (wr || rd)) mbp = ~mbp;
    if (wr && (a == 16'hF00C || a == 16'h000C)) mbp = 0;
  endtask

  function automatic logic [15:0] pick_addr(input int unsigned r);
    case (r % 24)
      0: return 16'hF010;  1: return 16'hF011;  2: return 16'hF000;  3: return 16'hF087;
      4: return 16'hF086;  5: return 16'hF001;  6: return 16'hF098;  7: return 16'hF012;
      8: return 16'hF013;  9: return 16'hF002; 10: return 16'hF083; 11: return 16'hF085;
      12: return 16'hF003; 13: return 16'hF099; 14: return 16'hF00C; 15: return 16'h000C;
      16: return 16'hF084; 17: return 16'hF004;
      default: return 16'(r >> 8);
    endcase
  endfunction

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    for (int c = 0; c < 2; c++) begin mreq[c] = '0; mtgt[c] = '0; mcnt[c] = '0; end
    mbp = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rd_data reset", {56'h0, rd_data}, 64'h0);
    compare_outputs("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_outputs("R1 after release");

    // R2/R3: byte pair through one shared port
    access(16'hF000, 1, 0, 8'h11, "R2 tgt0 lo");
    access(16'hF000, 1, 0, 8'h22, "R2 tgt0 hi");
    check("R2 tgt0 pair", {48'h0, tgt_addr[15:0]}, 64'h2211);
    // R3: pointer shared across channels: ch1 req now starts at low byte
    access(16'hF012, 1, 0, 8'hA1, "R3 req1 b0");
    access(16'hF013, 1, 0, 8'hA3, "R3 req1 b3");
    check("R3 req1 shared bp", {32'h0, req_addr[63:32]}, 64'hA3000_0A1 & 64'hFF0000FF);
    // R4: clear mid-pair with arbitrary data
    access(16'hF001, 1, 0, 8'h55, "R4 cnt0 lo");
    access(16'hF00C, 1, 0, 8'hFF, "R4 clear");
    access(16'hF001, 1, 0, 8'h66, "R4 cnt0 lo again");
    check("R4 clear restarts low", {40'h0, byte_cnt[23:0]}, 64'h000066);
    access(16'h000C, 1, 0, 8'h00, "R4 alt clear");
    // R5: direct port between pair halves keeps pointer
    access(16'hF011, 1, 0, 8'h33, "R5 req0 b2");
    access(16'hF087, 1, 0, 8'h77, "R5 direct tgt0 b2");
    access(16'hF086, 1, 0, 8'h88, "R5 direct tgt0 b3");
    access(16'hF099, 1, 0, 8'h99, "R5 direct cnt1 b2");
    access(16'hF011, 1, 0, 8'h44, "R5 req0 b3");
    check("R5 req0 upper", {48'h0, req_addr[31:16]}, 64'h4433);
    check("R5 tgt0 upper", {48'h0, tgt_addr[31:16]}, 64'h8877);
    // R7: unmapped write and read
    access(16'h1234, 1, 0, 8'hEE, "R7 unmapped wr");
    access(16'hF00C, 0, 1, 8'h00, "R7 clear addr read");
    access(16'hF084, 0, 1, 8'h00, "R7 unmapped rd");
    // R6: reads back, pointer flips on reads too
    access(16'hF000, 0, 1, 8'h00, "R6 rd tgt0 lo");
    access(16'hF000, 0, 1, 8'h00, "R6 rd tgt0 hi");
    // R3/R6: both strobes: old data read, single flip
    access(16'hF002, 1, 1, 8'h5A, "R3 dual strobe");
    access(16'hF002, 0, 1, 8'h00, "R3 after dual");
    compare_outputs("directed end");

    // Random mix
    for (int i = 0; i < 1500; i++) begin
      int unsigned r;
      logic [15:0] a;
      int op;
      r = $urandom;
      a = pick_addr(r);
      op = int'((r >> 5) % 4);
      access(a, op != 1, op != 0, 8'($urandom), "R2 random");
      if (i % 10 == 0) compare_outputs("R8 random");
    end
    compare_outputs("R8 final");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule